// File: doc/BRIEF.md
# ATA Command Decoder and Status Responder

This block sits behind the task-file registers of a storage device. When the host writes the command register, the block takes the command byte together with the features byte and the sector-count byte. It sorts the command into one of five classes: non-data, PIO read, PIO write, DMA, or internal verify. For a data command it works out how many sectors to move and sends a one-cycle start pulse, carrying the class and the sector count, to an external transfer engine. The engine then reports each finished sector back to the block.

The block runs every non-data command itself. Each one takes one busy cycle and then ends with an interrupt and, where needed, the abort error. This covers the power-mode commands under both of their opcodes, the multiple-block size setting, and the reliability-monitoring subcommands. Those subcommands are selected by the features byte and are gated by an enable flag that survives between commands. The status subcommand writes a fixed pair of signature bytes to the middle and high address registers.

Command writes that arrive while the device shows busy or data-request are dropped. The block keeps BSY and DRQ mutually exclusive.

Top module: `ata_cmd_decoder`

## Requirements
- R1: A command write accepted while idle starts a transfer one edge later for data opcodes. `xfer_start` pulses for one cycle, with `xfer_cls` encoded as 1 = PIO read (20h, C4h, ECh, E4h, and B0h with features D0h), 2 = PIO write (30h, C5h, E8h), 3 = DMA (C8h, CAh), 4 = verify (40h, 41h). During PIO and DMA transfers DRQ is 1 and BSY is 0.
- R2: For 20h, 30h, C4h, C5h, C8h, CAh, 40h and 41h, `xfer_nsec` equals the sector count, and a count of 0 gives 256. For ECh, E4h, E8h and the monitoring read, `xfer_nsec` is 1.
- R3: Opcode 00h does not start a transfer. BSY is high for one cycle, and on the next edge the interrupt pulses with `err_abrt` = 1.
- R4: A verify command holds BSY and never raises DRQ. It completes with a single interrupt after its last sector.
- R5: The power opcodes set `pwr_mode` (0 active, 1 idle, 2 standby, 3 sleep): E0h/94h and E2h/96h give standby, E1h/95h and E3h/97h give idle, E6h/99h gives sleep. Each takes one BSY cycle and then one interrupt without error. The mode is active after reset.
- R6: Opcodes E5h and 98h leave the mode unchanged. On the completion edge they pulse `sc_we`, with `sc_val` = FFh when the mode is active or idle and 00h when it is standby or sleep.
- R7: Opcode B0h dispatches on the features byte: D8h enable, D9h disable, D2h and D4h complete without error, DAh status, D0h one-sector PIO read. Any other features value is aborted.
- R8: While monitoring is disabled, every B0h subcommand except D8h is aborted. D8h issued while already enabled completes without error and changes nothing. Monitoring is enabled after reset.
- R9: The status subcommand pulses `lba_we` on its completion edge. It writes `lba_mid` = 4Fh and `lba_high` = C2h when `thresh_hit` is 0, and F4h and 2Ch when `thresh_hit` is 1.
- R10: During a transfer, single-sector PIO commands interrupt on every sector, and C4h/C5h interrupt once per block of the set size. DMA and verify interrupt only at the end. The last sector always interrupts and clears DRQ and BSY.
- R11: Any opcode outside the recognised set is aborted like 00h, with no transfer.
- R12: C6h with a count of 0 or a power of two up to MAX_MULT sets the block size and completes without error. Any other count is aborted and keeps the old size. C4h and C5h are aborted while the size is 0.
- R13: A command write while BSY or DRQ is 1 is ignored. It starts nothing and changes no mode.
- R14: Opcodes E7h, EFh and 90h take one BSY cycle, then one interrupt without error, with no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command opcode |
| cmd_feat | input | 8 | Features byte |
| cmd_count | input | SC_W | Sector count byte |
| thresh_hit | input | 1 | Reliability threshold exceeded |
| sec_done | input | 1 | Transfer engine finished one sector |
| bsy | output | 1 | Busy status |
| drq | output | 1 | Data request status |
| err_abrt | output | 1 | Error with command aborted |
| irq | output | 1 | Interrupt pulse |
| xfer_start | output | 1 | Start pulse to transfer engine |
| xfer_cls | output | 3 | Transfer class |
| xfer_nsec | output | SC_W+1 | Sectors to transfer |
| pwr_mode | output | 2 | Current power mode |
| sc_we | output | 1 | Sector-count result write |
| sc_val | output | 8 | Sector-count result value |
| lba_we | output | 1 | Address signature write |
| lba_mid | output | 8 | Middle address register value |
| lba_high | output | 8 | High address register value |

## Verification
Every result is due on a fixed edge:
- The start pulse, or BSY for a non-data command, appears on the first edge after the edge that takes the command write.
- The completion interrupt, the error bit, the mode change and the sector-count or signature writes appear on the second edge.
- During a transfer, interrupts appear on the same edge that takes the engine's sector strobe.

The bench drives inputs and samples outputs on the falling edge. At each falling edge it compares every output with a behavioural model advanced on the rising edge. Directed checks sample exactly one and two falling edges after a command and one falling edge after each sector strobe.

// File: rtl/atacmd_pkg.sv
package atacmd_pkg;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_PIN  = 3'd1,
    CLS_POUT = 3'd2,
    CLS_DMA  = 3'd3,
    CLS_VFY  = 3'd4
  } xfer_cls_e;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_IDLE    = 2'd1,
    PM_STANDBY = 2'd2,
    PM_SLEEP   = 2'd3
  } pwr_e;

  typedef enum logic [3:0] {
    OP_ABORT      = 4'd0,
    OP_DONE       = 4'd1,
    OP_XFER       = 4'd2,
    OP_PWR        = 4'd3,
    OP_CHKPWR     = 4'd4,
    OP_SETMULT    = 4'd5,
    OP_SMART_ON   = 4'd6,
    OP_SMART_OFF  = 4'd7,
    OP_SMART_STAT = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_XFER = 2'd2
  } st_e;

  localparam logic [7:0] SIG_OK_MID   = 8'h4F;
  localparam logic [7:0] SIG_OK_HIGH  = 8'hC2;
  localparam logic [7:0] SIG_BAD_MID  = 8'hF4;
  localparam logic [7:0] SIG_BAD_HIGH = 8'h2C;

endpackage

// File: rtl/atacmd_decode.sv
module atacmd_decode
  import atacmd_pkg::*;
#(
  parameter int SC_W     = 8,
  parameter int MAX_MULT = 16
) (
  input  logic [7:0]      opcode,
  input  logic [7:0]      feat,
  input  logic [SC_W-1:0] count,
  input  logic            smart_en,
  input  logic [SC_W-1:0] mult_size,
  input  pwr_e            pwr_now,
  output op_e             op,
  output xfer_cls_e       cls,
  output logic [SC_W:0]   nsec,
  output logic [SC_W:0]   blk,
  output pwr_e            pwr_new,
  output logic [7:0]      sc_ret
);

  localparam logic [SC_W:0] FULL_CNT = {1'b1, {SC_W{1'b0}}};
  localparam logic [SC_W:0] ONE      = {{SC_W{1'b0}}, 1'b1};
  localparam logic [SC_W:0] MULT_LIM = (SC_W+1)'(MAX_MULT);

  logic [SC_W:0] cnt_ext;
  logic          mult_ok;

  // zero count selects the full range
  assign cnt_ext = (count == '0) ? FULL_CNT : {1'b0, count};
  assign mult_ok = (count == '0) ||
                   (((count & (count - 1'b1)) == '0) && ({1'b0, count} <= MULT_LIM));

  always_comb begin
    op      = OP_ABORT;
    cls     = CLS_NONE;
    nsec    = '0;
    blk     = '0;
    pwr_new = pwr_now;
    sc_ret  = 8'h00;
    case (opcode)
      8'h20: begin op = OP_XFER; cls = CLS_PIN;  nsec = cnt_ext; blk = ONE; end
      8'h30: begin op = OP_XFER; cls = CLS_POUT; nsec = cnt_ext; blk = ONE; end
      8'hC8: begin op = OP_XFER; cls = CLS_DMA;  nsec = cnt_ext; end
      8'hCA: begin op = OP_XFER; cls = CLS_DMA;  nsec = cnt_ext; end
      8'h40, 8'h41: begin op = OP_XFER; cls = CLS_VFY; nsec = cnt_ext; end
      8'hC4, 8'hC5: begin
        if (mult_size != '0) begin
          op   = OP_XFER;
          cls  = (opcode == 8'hC4) ? CLS_PIN : CLS_POUT;
          nsec = cnt_ext;
          blk  = {1'b0, mult_size};
        end
      end
      8'hEC, 8'hE4: begin op = OP_XFER; cls = CLS_PIN;  nsec = ONE; blk = ONE; end
      8'hE8:        begin op = OP_XFER; cls = CLS_POUT; nsec = ONE; blk = ONE; end
      8'hE7, 8'hEF, 8'h90: op = OP_DONE;
      8'hC6: begin
        if (mult_ok) op = OP_SETMULT;
      end
      8'hE0, 8'h94, 8'hE2, 8'h96: begin op = OP_PWR; pwr_new = PM_STANDBY; end
      8'hE1, 8'h95, 8'hE3, 8'h97: begin op = OP_PWR; pwr_new = PM_IDLE; end
      8'hE6, 8'h99:               begin op = OP_PWR; pwr_new = PM_SLEEP; end
      8'hE5, 8'h98: begin
        op     = OP_CHKPWR;
        sc_ret = (pwr_now == PM_ACTIVE || pwr_now == PM_IDLE) ? 8'hFF : 8'h00;
      end
      8'hB0: begin
        if (feat == 8'hD8) begin
          op = OP_SMART_ON;
        end else if (smart_en) begin
          case (feat)
            8'hD9:        op = OP_SMART_OFF;
            8'hD2, 8'hD4: op = OP_DONE;
            8'hDA:        op = OP_SMART_STAT;
            8'hD0: begin op = OP_XFER; cls = CLS_PIN; nsec = ONE; blk = ONE; end
            default:      op = OP_ABORT;
          endcase
        end
      end
      default: op = OP_ABORT;
    endcase
  end

endmodule

// File: rtl/atacmd_modes.sv
module atacmd_modes
  import atacmd_pkg::*;
#(
  parameter int SC_W      = 8,
  parameter bit SMART_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  op_e             op,
  input  pwr_e            pwr_new,
  input  logic [SC_W-1:0] count_in,
  output logic            smart_en,
  output pwr_e            pwr_mode,
  output logic [SC_W-1:0] mult_size
);

  always_ff @(posedge clk) begin
    if (rst) begin
      smart_en  <= SMART_RST;
      pwr_mode  <= PM_ACTIVE;
      mult_size <= '0;
    end else if (commit) begin
      case (op)
        OP_PWR:       pwr_mode  <= pwr_new;
        OP_SETMULT:   mult_size <= count_in;
        OP_SMART_ON:  smart_en  <= 1'b1;
        OP_SMART_OFF: smart_en  <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/atacmd_track.sv
module atacmd_track #(
  parameter int SC_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SC_W:0] nsec,
  input  logic [SC_W:0] blk,
  input  logic          sec_done,
  output logic          last_sec,
  output logic          blk_edge
);

  localparam logic [SC_W:0] ONE = {{SC_W{1'b0}}, 1'b1};

  logic [SC_W:0] rem;
  logic [SC_W:0] bsize;
  logic [SC_W:0] inblk;

  assign last_sec = sec_done && (rem == ONE);
  assign blk_edge = sec_done && !last_sec && (bsize != '0) && ((inblk + ONE) == bsize);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      bsize <= '0;
      inblk <= '0;
    end else if (load) begin
      rem   <= nsec;
      bsize <= blk;
      inblk <= '0;
    end else if (sec_done && rem != '0) begin
      rem   <= rem - ONE;
      inblk <= blk_edge ? '0 : inblk + ONE;
    end
  end

endmodule

// File: rtl/ata_cmd_decoder.sv
module ata_cmd_decoder
  import atacmd_pkg::*;
#(
  parameter int SC_W      = 8,
  parameter int MAX_MULT  = 16,
  parameter bit SMART_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic [7:0]      cmd_code,
  input  logic [7:0]      cmd_feat,
  input  logic [SC_W-1:0] cmd_count,
  input  logic            thresh_hit,
  input  logic            sec_done,
  output logic            bsy,
  output logic            drq,
  output logic            err_abrt,
  output logic            irq,
  output logic            xfer_start,
  output logic [2:0]      xfer_cls,
  output logic [SC_W:0]   xfer_nsec,
  output logic [1:0]      pwr_mode,
  output logic            sc_we,
  output logic [7:0]      sc_val,
  output logic            lba_we,
  output logic [7:0]      lba_mid,
  output logic [7:0]      lba_high
);

  st_e             st;
  op_e             dec_op;
  xfer_cls_e       dec_cls;
  logic [SC_W:0]   dec_nsec;
  logic [SC_W:0]   dec_blk;
  pwr_e            dec_pwr;
  logic [7:0]      dec_sc;

  op_e             op_q;
  pwr_e            pwr_q;
  logic [7:0]      sc_q;
  logic [SC_W-1:0] cnt_q;

  logic            smart_en;
  pwr_e            mode_now;
  logic [SC_W-1:0] mult_size;
  logic            last_sec;
  logic            blk_edge;
  logic            accept;
  logic            load;

  assign accept   = (st == ST_IDLE) && cmd_wr;
  assign load     = accept && (dec_op == OP_XFER);
  assign pwr_mode = mode_now;

  atacmd_decode #(.SC_W(SC_W), .MAX_MULT(MAX_MULT)) u_dec (
    .opcode    (cmd_code),
    .feat      (cmd_feat),
    .count     (cmd_count),
    .smart_en  (smart_en),
    .mult_size (mult_size),
    .pwr_now   (mode_now),
    .op        (dec_op),
    .cls       (dec_cls),
    .nsec      (dec_nsec),
    .blk       (dec_blk),
    .pwr_new   (dec_pwr),
    .sc_ret    (dec_sc)
  );

  atacmd_modes #(.SC_W(SC_W), .SMART_RST(SMART_RST)) u_modes (
    .clk       (clk),
    .rst       (rst),
    .commit    (st == ST_EXEC),
    .op        (op_q),
    .pwr_new   (pwr_q),
    .count_in  (cnt_q),
    .smart_en  (smart_en),
    .pwr_mode  (mode_now),
    .mult_size (mult_size)
  );

  atacmd_track #(.SC_W(SC_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .nsec     (dec_nsec),
    .blk      (dec_blk),
    .sec_done (sec_done && (st == ST_XFER)),
    .last_sec (last_sec),
    .blk_edge (blk_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      bsy        <= 1'b0;
      drq        <= 1'b0;
      err_abrt   <= 1'b0;
      irq        <= 1'b0;
      xfer_start <= 1'b0;
      xfer_cls   <= 3'd0;
      xfer_nsec  <= '0;
      sc_we      <= 1'b0;
      sc_val     <= 8'h00;
      lba_we     <= 1'b0;
      lba_mid    <= 8'h00;
      lba_high   <= 8'h00;
      op_q       <= OP_DONE;
      pwr_q      <= PM_ACTIVE;
      sc_q       <= 8'h00;
      cnt_q      <= '0;
    end else begin
      irq        <= 1'b0;
      xfer_start <= 1'b0;
      sc_we      <= 1'b0;
      lba_we     <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_wr) begin
            err_abrt <= 1'b0;
            if (dec_op == OP_XFER) begin
              st         <= ST_XFER;
              xfer_start <= 1'b1;
              xfer_cls   <= dec_cls;
              xfer_nsec  <= dec_nsec;
              bsy        <= (dec_cls == CLS_VFY);
              drq        <= (dec_cls != CLS_VFY);
            end else begin
              st    <= ST_EXEC;
              bsy   <= 1'b1;
              op_q  <= dec_op;
              pwr_q <= dec_pwr;
              sc_q  <= dec_sc;
              cnt_q <= cmd_count;
            end
          end
        end
        ST_EXEC: begin
          st  <= ST_IDLE;
          bsy <= 1'b0;
          irq <= 1'b1;
          case (op_q)
            OP_ABORT: err_abrt <= 1'b1;
            OP_CHKPWR: begin
              sc_we  <= 1'b1;
              sc_val <= sc_q;
            end
            OP_SMART_STAT: begin
              lba_we   <= 1'b1;
              lba_mid  <= thresh_hit ? SIG_BAD_MID  : SIG_OK_MID;
              lba_high <= thresh_hit ? SIG_BAD_HIGH : SIG_OK_HIGH;
            end
            default: ;
          endcase
        end
        ST_XFER: begin
          if (last_sec) begin
            st  <= ST_IDLE;
            bsy <= 1'b0;
            drq <= 1'b0;
            irq <= 1'b1;
          end else if (blk_edge) begin
            irq <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/atacmd_chk.sv
module atacmd_chk #(
  parameter int SC_W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_wr,
  input logic [7:0]    cmd_code,
  input logic          bsy,
  input logic          drq,
  input logic          err_abrt,
  input logic          irq,
  input logic          xfer_start,
  input logic [2:0]    xfer_cls,
  input logic [SC_W:0] xfer_nsec,
  input logic          lba_we,
  input logic [7:0]    lba_mid,
  input logic [7:0]    lba_high
);

  a_r1_start_class: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (xfer_cls >= 3'd1 && xfer_cls <= 3'd4 && xfer_nsec != '0));

  a_r1_start_single: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  a_r3_nop_aborts: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !bsy && !drq && cmd_code == 8'h00)
      |=> (bsy && !xfer_start) ##1 (irq && err_abrt && !bsy));

  a_r4_verify_no_drq: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && xfer_cls == 3'd4) |-> (bsy && !drq));

  a_r4_bsy_drq_excl: assert property (@(posedge clk) disable iff (rst)
    !(bsy && drq));

  a_r5_bsy_fall_irq: assert property (@(posedge clk) disable iff (rst)
    ($fell(bsy) && !drq) |-> irq);

  a_r9_sig_pair: assert property (@(posedge clk) disable iff (rst)
    lba_we |-> ((lba_mid == 8'h4F && lba_high == 8'hC2) ||
                (lba_mid == 8'hF4 && lba_high == 8'h2C)));

  a_r13_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (bsy || drq)) |=> !xfer_start);

endmodule

bind ata_cmd_decoder atacmd_chk #(.SC_W(SC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_wr     (cmd_wr),
  .cmd_code   (cmd_code),
  .bsy        (bsy),
  .drq        (drq),
  .err_abrt   (err_abrt),
  .irq        (irq),
  .xfer_start (xfer_start),
  .xfer_cls   (xfer_cls),
  .xfer_nsec  (xfer_nsec),
  .lba_we     (lba_we),
  .lba_mid    (lba_mid),
  .lba_high   (lba_high)
);

// File: tb/sim_ata_cmd_decoder.sv
`timescale 1ns/1ps
module sim_ata_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic [7:0] cmd_feat = 8'h00;
  logic [7:0] cmd_count = 8'h00;
  logic       thresh_hit = 1'b0;
  logic       sec_done = 1'b0;
  logic       bsy, drq, err_abrt, irq, xfer_start;
  logic [2:0] xfer_cls;
  logic [8:0] xfer_nsec;
  logic [1:0] pwr_mode;
  logic       sc_we, lba_we;
  logic [7:0] sc_val, lba_mid, lba_high;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  ata_cmd_decoder u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .cmd_feat(cmd_feat),
    .cmd_count(cmd_count), .thresh_hit(thresh_hit), .sec_done(sec_done),
    .bsy(bsy), .drq(drq), .err_abrt(err_abrt), .irq(irq), .xfer_start(xfer_start),
    .xfer_cls(xfer_cls), .xfer_nsec(xfer_nsec), .pwr_mode(pwr_mode), .sc_we(sc_we),
    .sc_val(sc_val), .lba_we(lba_we), .lba_mid(lba_mid), .lba_high(lba_high)
  );

  // behavioural reference, advanced on each rising edge
  int m_st, m_cls, m_nsec, m_pwr, m_sc, m_mid, m_high, m_mult, m_rem, m_blk, m_inblk;
  int p_kind, p_pwr, p_sc;
  bit m_bsy, m_drq, m_err, m_irq, m_start, m_scwe, m_lbawe, m_smart;

  // kinds: 0 abort 1 plain 2 transfer 3 power 4 query 5 setmult 6 mon-on 7 mon-off 8 status
  function automatic void classify(input int op, input int f, input int c,
                                   output int kind, output int cls, output int n,
                                   output int blk, output int pw, output int sc);
    int full;
    full = (c == 0) ? 256 : c;
    kind = 0; cls = 0; n = 0; blk = 0; pw = m_pwr; sc = 0;
    if (op == 'h20 || op == 'h30) begin kind = 2; cls = (op == 'h20) ? 1 : 2; n = full; blk = 1; end
    else if (op == 'hC8 || op == 'hCA) begin kind = 2; cls = 3; n = full; end
    else if (op == 'h40 || op == 'h41) begin kind = 2; cls = 4; n = full; end
    else if (op == 'hC4 || op == 'hC5) begin
      if (m_mult != 0) begin kind = 2; cls = (op == 'hC4) ? 1 : 2; n = full; blk = m_mult; end
    end
    else if (op == 'hEC || op == 'hE4) begin kind = 2; cls = 1; n = 1; blk = 1; end
    else if (op == 'hE8) begin kind = 2; cls = 2; n = 1; blk = 1; end
    else if (op == 'hE7 || op == 'hEF || op == 'h90) kind = 1;
    else if (op == 'hC6) begin
      if (c == 0 || c == 1 || c == 2 || c == 4 || c == 8 || c == 16) kind = 5;
    end
    else if (op == 'hE0 || op == 'h94 || op == 'hE2 || op == 'h96) begin kind = 3; pw = 2; end
    else if (op == 'hE1 || op == 'h95 || op == 'hE3 || op == 'h97) begin kind = 3; pw = 1; end
    else if (op == 'hE6 || op == 'h99) begin kind = 3; pw = 3; end
    else if (op == 'hE5 || op == 'h98) begin kind = 4; sc = (m_pwr <= 1) ? 255 : 0; end
    else if (op == 'hB0) begin
      if (f == 'hD8) kind = 6;
      else if (m_smart) begin
        if (f == 'hD9) kind = 7;
        else if (f == 'hD2 || f == 'hD4) kind = 1;
        else if (f == 'hDA) kind = 8;
        else if (f == 'hD0) begin kind = 2; cls = 1; n = 1; blk = 1; end
      end
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cls = 0; m_nsec = 0; m_pwr = 0; m_sc = 0; m_mid = 0; m_high = 0;
      m_mult = 0; m_rem = 0; m_blk = 0; m_inblk = 0; p_kind = 1; p_pwr = 0; p_sc = 0;
      m_bsy = 0; m_drq = 0; m_err = 0; m_irq = 0; m_start = 0; m_scwe = 0; m_lbawe = 0;
      m_smart = 1;
    end else begin
      m_irq = 0; m_start = 0; m_scwe = 0; m_lbawe = 0;
      if (m_st == 0) begin
        if (cmd_wr) begin
          int k, c, n, b, pw, sc;
          classify(cmd_code, cmd_feat, cmd_count, k, c, n, b, pw, sc);
          m_err = 0;
          if (k == 2) begin
            m_st = 2; m_start = 1; m_cls = c; m_nsec = n; m_rem = n; m_blk = b; m_inblk = 0;
            m_bsy = (c == 4); m_drq = (c != 4);
          end else begin
            m_st = 1; m_bsy = 1; p_kind = k; p_pwr = pw; p_sc = sc;
            if (k == 5) m_blk = cmd_count;
          end
        end
      end else if (m_st == 1) begin
        m_st = 0; m_bsy = 0; m_irq = 1;
        case (p_kind)
          0: m_err = 1;
          3: m_pwr = p_pwr;
          4: begin m_scwe = 1; m_sc = p_sc; end
          5: m_mult = m_blk;
          6: m_smart = 1;
          7: m_smart = 0;
          8: begin
            m_lbawe = 1;
            m_mid  = thresh_hit ? 'hF4 : 'h4F;
            m_high = thresh_hit ? 'h2C : 'hC2;
          end
          default: ;
        endcase
      end else begin
        if (sec_done) begin
          if (m_rem == 1) begin
            m_st = 0; m_bsy = 0; m_drq = 0; m_irq = 1; m_rem = 0;
          end else begin
            m_rem--;
            if (m_blk != 0) begin
              m_inblk++;
              if (m_inblk == m_blk) begin m_irq = 1; m_inblk = 0; end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [44:0] act, exp;
      act = {bsy, drq, err_abrt, irq, xfer_start, xfer_cls, xfer_nsec, pwr_mode,
             sc_we, sc_val, lba_we, lba_mid, lba_high};
      exp = {m_bsy, m_drq, m_err, m_irq, m_start, 3'(m_cls), 9'(m_nsec), 2'(m_pwr),
             m_scwe, 8'(m_sc), m_lbawe, 8'(m_mid), 8'(m_high)};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s model compare at %0t actual=%h expected=%h", cur_req, $time, act, exp);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] f, input logic [7:0] c);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_code = op; cmd_feat = f; cmd_count = c;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  // non-data command: busy one cycle, then interrupt
  task automatic nd(input logic [7:0] op, input logic [7:0] f, input logic [7:0] c,
                    input bit exp_err, input int exp_sc, input string tag);
    cur_req = tag;
    issue(op, f, c);
    chk(tag, {bsy, drq, xfer_start}, 3'b100);
    @(negedge clk);
    chk(tag, {irq, err_abrt, bsy}, {1'b1, exp_err, 1'b0});
    if (exp_sc >= 0) chk(tag, {sc_we, sc_val}, {1'b1, 8'(exp_sc)});
  endtask

  task automatic xf(input logic [7:0] op, input logic [7:0] f, input logic [7:0] c,
                    input int ecls, input int en, input int eirq, input string tag);
    int irqs;
    bit drq_seen;
    irqs = 0; drq_seen = 0;
    cur_req = tag;
    issue(op, f, c);
    chk(tag, {xfer_start, 23'(xfer_cls), 9'(xfer_nsec)}, {1'b1, 23'(ecls), 9'(en)});
    chk(tag, {bsy, drq}, (ecls == 4) ? 2'b10 : 2'b01);
    for (int i = 0; i < en; i++) begin
      @(negedge clk); sec_done = 1'b1;
      @(negedge clk); sec_done = 1'b0;
      if (irq) irqs++;
      if (drq) drq_seen = 1;
    end
    chk(tag, irqs, eirq);
    chk(tag, {bsy, drq}, 2'b00);
    if (ecls == 4) chk({tag, " drq"}, drq_seen, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R5";
    chk("R5 reset state", {bsy, drq, err_abrt, irq, xfer_start, pwr_mode}, 7'b0);

    nd(8'hE7, 8'h00, 8'h00, 0, -1, "R14 flush");
    nd(8'hEF, 8'h03, 8'h45, 0, -1, "R14 features");
    nd(8'h90, 8'h00, 8'h00, 0, -1, "R14 diag");
    nd(8'h00, 8'h00, 8'h00, 1, -1, "R3 nop");
    nd(8'h5A, 8'h00, 8'h00, 1, -1, "R11 unknown");

    xf(8'h20, 8'h00, 8'd3, 1, 3, 3, "R1 R10 read single");
    xf(8'h30, 8'h00, 8'd0, 2, 256, 256, "R2 write full count");
    xf(8'hC8, 8'h00, 8'd2, 3, 2, 1, "R10 dma read");
    xf(8'hCA, 8'h00, 8'd1, 3, 1, 1, "R1 dma write");
    xf(8'hEC, 8'h00, 8'd7, 1, 1, 1, "R2 identify");
    xf(8'hE4, 8'h00, 8'd0, 1, 1, 1, "R2 buffer read");
    xf(8'hE8, 8'h00, 8'd9, 2, 1, 1, "R2 buffer write");
    xf(8'h40, 8'h00, 8'd2, 4, 2, 1, "R4 verify");
    xf(8'h41, 8'h00, 8'd0, 4, 256, 1, "R4 verify full");

    nd(8'hC4, 8'h00, 8'd4, 1, -1, "R12 multi no size");
    nd(8'hC6, 8'h00, 8'd3, 1, -1, "R12 size not pow2");
    nd(8'hC6, 8'h00, 8'd4, 0, -1, "R12 size 4");
    nd(8'hC6, 8'h00, 8'd32, 1, -1, "R12 size too big");
    xf(8'hC4, 8'h00, 8'd10, 1, 10, 3, "R10 R12 multi read");
    xf(8'hC5, 8'h00, 8'd8, 2, 8, 2, "R10 multi write");
    nd(8'hC6, 8'h00, 8'd0, 0, -1, "R12 size clear");
    nd(8'hC5, 8'h00, 8'd4, 1, -1, "R12 multi cleared");

    // command write during a transfer is dropped
    cur_req = "R13";
    issue(8'h20, 8'h00, 8'd2);
    issue(8'hE6, 8'h00, 8'h00);
    chk("R13 ignored start", {xfer_start, drq, bsy}, 3'b010);
    @(negedge clk);
    chk("R13 no mode change", pwr_mode, 0);
    repeat (2) begin
      @(negedge clk); sec_done = 1'b1;
      @(negedge clk); sec_done = 1'b0;
    end
    chk("R13 finished", {bsy, drq, pwr_mode}, 4'b0000);

    nd(8'hE5, 8'h00, 8'h00, 0, 8'hFF, "R6 check active");
    nd(8'hE0, 8'h00, 8'h00, 0, -1, "R5 standby imm");
    chk("R5 mode", pwr_mode, 2);
    nd(8'h98, 8'h00, 8'h00, 0, 8'h00, "R6 check standby");
    nd(8'h95, 8'h00, 8'h00, 0, -1, "R5 idle imm alt");
    chk("R5 mode", pwr_mode, 1);
    nd(8'hE5, 8'h00, 8'h00, 0, 8'hFF, "R6 check idle");
    nd(8'h99, 8'h00, 8'h00, 0, -1, "R5 sleep alt");
    chk("R5 mode", pwr_mode, 3);
    nd(8'h96, 8'h00, 8'h00, 0, -1, "R5 standby alt");
    chk("R5 mode", pwr_mode, 2);
    nd(8'hE3, 8'h00, 8'h05, 0, -1, "R5 idle");
    chk("R5 mode", pwr_mode, 1);
    nd(8'hE2, 8'h00, 8'h00, 0, -1, "R5 standby");
    nd(8'h97, 8'h00, 8'h00, 0, -1, "R5 idle alt");
    nd(8'h94, 8'h00, 8'h00, 0, -1, "R5 standby imm alt");
    nd(8'hE1, 8'h00, 8'h00, 0, -1, "R5 idle imm");
    nd(8'hE6, 8'h00, 8'h00, 0, -1, "R5 sleep");
    chk("R5 mode", pwr_mode, 3);
    nd(8'hE5, 8'h00, 8'h00, 0, 8'h00, "R6 check sleep");
    chk("R6 mode kept", pwr_mode, 3);

    thresh_hit = 1'b0;
    nd(8'hB0, 8'hDA, 8'h00, 0, -1, "R9 status ok");
    chk("R9 sig ok", {lba_mid, lba_high}, 16'h4FC2);
    thresh_hit = 1'b1;
    nd(8'hB0, 8'hDA, 8'h00, 0, -1, "R9 status bad");
    chk("R9 sig bad", {lba_mid, lba_high}, 16'hF42C);
    thresh_hit = 1'b0;
    nd(8'hB0, 8'hD2, 8'hF1, 0, -1, "R7 autosave");
    nd(8'hB0, 8'hD4, 8'h00, 0, -1, "R7 offline");
    nd(8'hB0, 8'h11, 8'h00, 1, -1, "R7 bad feature");
    xf(8'hB0, 8'hD0, 8'h00, 1, 1, 1, "R7 read data");
    nd(8'hB0, 8'hD9, 8'h00, 0, -1, "R7 disable");
    nd(8'hB0, 8'hDA, 8'h00, 1, -1, "R8 status while off");
    nd(8'hB0, 8'hD0, 8'h00, 1, -1, "R8 read while off");
    nd(8'hB0, 8'hD9, 8'h00, 1, -1, "R8 disable while off");
    nd(8'hB0, 8'hD8, 8'h00, 0, -1, "R8 enable");
    nd(8'hB0, 8'hD8, 8'h00, 0, -1, "R8 enable again");
    nd(8'hB0, 8'hDA, 8'h00, 0, -1, "R8 status after enable");
    chk("R8 sig", {lba_mid, lba_high}, 16'h4FC2);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule